// File: doc/BRIEF.md
# Deterministic Dual-Issue Thread Scheduler

This block sits in front of one processing element that has a pipelined adder and a pipelined multiplier. Up to four independent data threads each present the head instruction of their queue: a valid flag, a flag saying its operand data is present, the unit it needs, a destination register and two operand values. Each cycle the scheduler issues zero, one or two of these heads. Two heads issued together always come from two threads and go to two units. The same input history always gives the same issue sequence, so the data streams of a systolic array stay aligned.

Both units return results over one shared write-back bus. At issue, the scheduler books the bus cycle in which the result will complete. If that cycle is already booked by an older instruction, the result is booked for the following cycle and waits there in a one-entry holding register. If both cycles are booked, the instruction is not issued and its thread is passed over for that cycle. The units are simple stubs: the adder returns the sum, the multiplier the low product bits.

Top module: `dual_issue_sched`

## Requirements
- R1: At most two instructions issue per cycle (slot 0 and slot 1). Slot 1 is used only in a cycle where slot 0 is used.
- R2: The two slots of a cycle always carry different threads.
- R3: The two slots of a cycle always target different units. The unit code is `q_unit` bit 0 for the adder and 1 for the multiplier.
- R4: A thread is issued only when both its `q_valid` and `q_ready` bits are high. `q_pop` is one-hot per issued thread and matches the slot outputs.
- R5: Slot 0 takes the first eligible thread in rotation order. The rotation starts at the thread after the one slot 0 last took. After reset it starts at thread 0.
- R6: Slot 1 takes the first eligible thread after the slot 0 thread, in the same rotation order, that needs the other unit.
- R7: A thread whose result could find no free bus cycle is skipped. A free cycle means either its completion cycle or the cycle after it. The skipped thread's head stays in place, and later threads in the rotation may issue.
- R8: The bus carries one result per cycle. When two results complete in the same cycle, the older issued one goes first and the younger one appears exactly one cycle later.
- R9: The adder result is the operand sum and the multiplier result is the low 16 bits of the product. With the default latencies (adder 1, multiplier 3), a result that is not delayed appears on `wb_*` latency+1 cycles after issue.
- R10: During reset nothing issues and `wb_vld` is low.
- R11: Replaying the same input sequence after reset reproduces the same issue order and write-back sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 4 | Per-thread: queue head present |
| q_ready | input | 4 | Per-thread: operand data of the head available |
| q_unit | input | 4 | Per-thread unit: 0 adder, 1 multiplier |
| q_dst | input | 16 | Per-thread destination register, 4 bits each |
| q_opa | input | 64 | Per-thread first operand, 16 bits each |
| q_opb | input | 64 | Per-thread second operand, 16 bits each |
| q_pop | output | 4 | Per-thread: head consumed this cycle |
| s0_vld | output | 1 | Slot 0 issues |
| s0_thr | output | 2 | Slot 0 thread |
| s1_vld | output | 1 | Slot 1 issues |
| s1_thr | output | 2 | Slot 1 thread |
| wb_vld | output | 1 | Result bus valid |
| wb_thr | output | 2 | Thread of the result |
| wb_dst | output | 4 | Destination register of the result |
| wb_data | output | 16 | Result value |

## Verification
The slot rules are checked by assertions on every cycle: slot 1 only alongside slot 0, distinct threads, distinct units, only ready heads, and a pop count that matches the slots. The same assertions check that the bus never gets two direct completions and that the holding register is never overwritten while it is still full. Only the bench's scenarios can show the rotation order, the skipping of a bus-blocked thread, the exact cycle and order of collided results, the computed values, and the repeatability of the whole sequence across two resets.

// File: rtl/dis_pkg.sv
package dis_pkg;

    localparam int unsigned NTHR    = 4;
    localparam int unsigned TW      = $clog2(NTHR);
    localparam int unsigned DW      = 16;
    localparam int unsigned RW      = 4;
    localparam int unsigned ADD_LAT = 1;
    localparam int unsigned MUL_LAT = 3;
    localparam int unsigned BOOK_D  = MUL_LAT + 2;

    typedef enum logic {
        FU_ADD = 1'b0,
        FU_MUL = 1'b1
    } fu_e;

    typedef struct packed {
        logic [TW-1:0] thr;
        logic [RW-1:0] dst;
        logic [DW-1:0] data;
        logic          late;
    } res_t;

    function automatic int unsigned fu_lat(input logic unit);
        return (unit == FU_MUL) ? MUL_LAT : ADD_LAT;
    endfunction

    function automatic logic [TW-1:0] ring_next(input logic [TW-1:0] idx);
        return (int'(idx) == NTHR - 1) ? '0 : TW'(int'(idx) + 1);
    endfunction

endpackage

// File: rtl/dis_rr_pick.sv
module dis_rr_pick #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [IW-1:0] start,
    input  logic [N-1:0]  elig,
    output logic          found,
    output logic [IW-1:0] pick
);
    // Reverse scan: the last hit written is the first in rotation order.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(start) + k) % N;
            if (elig[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/dis_bus_book.sv
module dis_bus_book
    import dis_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       s0_vld,
    input  logic       s0_unit,
    input  logic       s1_vld,
    input  logic       s1_unit,
    output logic [1:0] avail0,
    output logic [1:0] late0,
    output logic [1:0] avail1,
    output logic [1:0] late1
);
    logic [BOOK_D-1:0] busy_q;
    logic [BOOK_D-1:0] map1;
    logic [BOOK_D-1:0] map2;

    function automatic logic [BOOK_D-1:0] book_bit(input logic [BOOK_D-1:0] m,
                                                    input logic unit);
        int unsigned l;
        logic [BOOK_D-1:0] b;
        l = fu_lat(unit);
        b = '0;
        if (!m[l]) b[l] = 1'b1;
        else       b[l+1] = 1'b1;
        return b;
    endfunction

    generate
        for (genvar u = 0; u < 2; u++) begin : g_unit
            localparam int unsigned L = (u == 1) ? MUL_LAT : ADD_LAT;
            assign avail0[u] = !(busy_q[L] && busy_q[L+1]);
            assign late0[u]  = busy_q[L];
            assign avail1[u] = !(map1[L] && map1[L+1]);
            assign late1[u]  = map1[L];
        end
    endgenerate

    assign map1 = busy_q | (s0_vld ? book_bit(busy_q, s0_unit) : '0);
    assign map2 = map1   | (s1_vld ? book_bit(map1, s1_unit) : '0);

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= map2 >> 1;
    end
endmodule

// File: rtl/dis_fu_pipe.sv
module dis_fu_pipe
    import dis_pkg::*;
#(
    parameter int unsigned LAT    = 1,
    parameter bit          IS_MUL = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [TW-1:0] in_thr,
    input  logic [RW-1:0] in_dst,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic          in_late,
    output logic          out_vld,
    output res_t          out_res
);
    logic [DW-1:0] result;
    logic [LAT-1:0] vld_q;
    res_t          stg_q [LAT];

    generate
        if (IS_MUL) begin : g_mul
            assign result = in_a * in_b;
        end else begin : g_add
            assign result = in_a + in_b;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else begin
            vld_q[0] <= in_vld;
            for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        stg_q[0] <= '{thr: in_thr, dst: in_dst, data: result, late: in_late};
        for (int i = 1; i < LAT; i++) stg_q[i] <= stg_q[i-1];
    end

    assign out_vld = vld_q[LAT-1];
    assign out_res = stg_q[LAT-1];
endmodule

// File: rtl/dis_wb_arb.sv
module dis_wb_arb
    import dis_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          add_done,
    input  res_t          add_res,
    input  logic          mul_done,
    input  res_t          mul_res,
    output logic          hold_vld,
    output logic          wb_vld,
    output logic [TW-1:0] wb_thr,
    output logic [RW-1:0] wb_dst,
    output logic [DW-1:0] wb_data
);
    res_t hold_q;
    res_t sel;
    logic sel_vld;
    logic add_now, mul_now, add_wait, mul_wait;

    assign add_now  = add_done && !add_res.late;
    assign mul_now  = mul_done && !mul_res.late;
    assign add_wait = add_done &&  add_res.late;
    assign mul_wait = mul_done &&  mul_res.late;

    always_comb begin
        sel_vld = 1'b1;
        if (hold_vld)     sel = hold_q;
        else if (mul_now) sel = mul_res;
        else if (add_now) sel = add_res;
        else begin
            sel     = '0;
            sel_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            wb_vld   <= 1'b0;
        end else begin
            hold_vld <= add_wait || mul_wait;
            wb_vld   <= sel_vld;
        end
    end

    always_ff @(posedge clk) begin
        hold_q  <= mul_wait ? mul_res : add_res;
        wb_thr  <= sel.thr;
        wb_dst  <= sel.dst;
        wb_data <= sel.data;
    end
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
    import dis_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NTHR-1:0]    q_valid,
    input  logic [NTHR-1:0]    q_ready,
    input  logic [NTHR-1:0]    q_unit,
    input  logic [NTHR*RW-1:0] q_dst,
    input  logic [NTHR*DW-1:0] q_opa,
    input  logic [NTHR*DW-1:0] q_opb,
    output logic [NTHR-1:0]    q_pop,
    output logic               s0_vld,
    output logic [TW-1:0]      s0_thr,
    output logic               s1_vld,
    output logic [TW-1:0]      s1_thr,
    output logic               wb_vld,
    output logic [TW-1:0]      wb_thr,
    output logic [RW-1:0]      wb_dst,
    output logic [DW-1:0]      wb_data
);
    logic [TW-1:0]   last_q;
    logic [TW-1:0]   start0, start1;
    logic [NTHR-1:0] elig0, elig1;
    logic [1:0]      avail0, late0, avail1, late1;
    logic            u0, u1;
    logic            add_from0, mul_from0, add_iss, mul_iss;
    logic [TW-1:0]   add_thr, mul_thr;
    logic            add_late, mul_late;
    logic            add_done, mul_done, hold_vld;
    res_t            add_res, mul_res;

    assign start0 = ring_next(last_q);
    assign start1 = ring_next(s0_thr);
    assign u0     = q_unit[s0_thr];
    assign u1     = q_unit[s1_thr];

    generate
        for (genvar t = 0; t < NTHR; t++) begin : g_thr
            assign elig0[t] = !rst && q_valid[t] && q_ready[t] && avail0[q_unit[t]];
            assign elig1[t] = !rst && s0_vld && q_valid[t] && q_ready[t]
                              && (q_unit[t] != u0) && avail1[q_unit[t]];
            assign q_pop[t] = (s0_vld && s0_thr == TW'(t)) || (s1_vld && s1_thr == TW'(t));
        end
    endgenerate

    dis_rr_pick #(.N(NTHR)) i_pick0 (
        .start(start0), .elig(elig0), .found(s0_vld), .pick(s0_thr)
    );

    dis_rr_pick #(.N(NTHR)) i_pick1 (
        .start(start1), .elig(elig1), .found(s1_vld), .pick(s1_thr)
    );

    dis_bus_book i_book (
        .clk(clk), .rst(rst),
        .s0_vld(s0_vld), .s0_unit(u0), .s1_vld(s1_vld), .s1_unit(u1),
        .avail0(avail0), .late0(late0), .avail1(avail1), .late1(late1)
    );

    always_ff @(posedge clk) begin
        if (rst)         last_q <= TW'(NTHR - 1);
        else if (s0_vld) last_q <= s0_thr;
    end

    // Each unit owns one operand read path into the per-thread operands.
    assign add_from0 = s0_vld && (u0 == FU_ADD);
    assign mul_from0 = s0_vld && (u0 == FU_MUL);
    assign add_iss   = add_from0 || (s1_vld && u1 == FU_ADD);
    assign mul_iss   = mul_from0 || (s1_vld && u1 == FU_MUL);
    assign add_thr   = add_from0 ? s0_thr : s1_thr;
    assign mul_thr   = mul_from0 ? s0_thr : s1_thr;
    assign add_late  = add_from0 ? late0[FU_ADD] : late1[FU_ADD];
    assign mul_late  = mul_from0 ? late0[FU_MUL] : late1[FU_MUL];

    dis_fu_pipe #(.LAT(ADD_LAT), .IS_MUL(1'b0)) i_add (
        .clk(clk), .rst(rst), .in_vld(add_iss), .in_thr(add_thr),
        .in_dst(q_dst[add_thr*RW +: RW]),
        .in_a(q_opa[add_thr*DW +: DW]), .in_b(q_opb[add_thr*DW +: DW]),
        .in_late(add_late), .out_vld(add_done), .out_res(add_res)
    );

    dis_fu_pipe #(.LAT(MUL_LAT), .IS_MUL(1'b1)) i_mul (
        .clk(clk), .rst(rst), .in_vld(mul_iss), .in_thr(mul_thr),
        .in_dst(q_dst[mul_thr*RW +: RW]),
        .in_a(q_opa[mul_thr*DW +: DW]), .in_b(q_opb[mul_thr*DW +: DW]),
        .in_late(mul_late), .out_vld(mul_done), .out_res(mul_res)
    );

    dis_wb_arb i_arb (
        .clk(clk), .rst(rst),
        .add_done(add_done), .add_res(add_res),
        .mul_done(mul_done), .mul_res(mul_res),
        .hold_vld(hold_vld),
        .wb_vld(wb_vld), .wb_thr(wb_thr), .wb_dst(wb_dst), .wb_data(wb_data)
    );
endmodule

// File: rtl/dual_issue_sched_chk.sv
module dual_issue_sched_chk
    import dis_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NTHR-1:0] q_valid,
    input logic [NTHR-1:0] q_ready,
    input logic [NTHR-1:0] q_unit,
    input logic [NTHR-1:0] q_pop,
    input logic            s0_vld,
    input logic [TW-1:0]   s0_thr,
    input logic            s1_vld,
    input logic [TW-1:0]   s1_thr,
    input logic            wb_vld,
    input logic            add_done,
    input logic            mul_done,
    input res_t            add_res,
    input res_t            mul_res,
    input logic            hold_vld
);
    a_r1_slot1_needs_slot0: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> s0_vld);

    a_r2_distinct_threads: assert property (@(posedge clk) disable iff (rst)
        (s0_vld && s1_vld) |-> (s0_thr != s1_thr));

    a_r3_distinct_units: assert property (@(posedge clk) disable iff (rst)
        (s0_vld && s1_vld) |-> (q_unit[s0_thr] != q_unit[s1_thr]));

    a_r4_slot0_ready: assert property (@(posedge clk) disable iff (rst)
        s0_vld |-> (q_valid[s0_thr] && q_ready[s0_thr]));

    a_r4_slot1_ready: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> (q_valid[s1_thr] && q_ready[s1_thr]));

    a_r4_pop_count: assert property (@(posedge clk) disable iff (rst)
        $countones(q_pop) == (32'(s0_vld) + 32'(s1_vld)));

    a_r8_one_direct: assert property (@(posedge clk) disable iff (rst)
        !(add_done && !add_res.late && mul_done && !mul_res.late));

    a_r8_hold_free: assert property (@(posedge clk) disable iff (rst)
        hold_vld |-> !((add_done && !add_res.late) || (mul_done && !mul_res.late)));

    a_r8_collide_two_beats: assert property (@(posedge clk) disable iff (rst)
        (add_done && mul_done) |=> wb_vld ##1 wb_vld);
endmodule

bind dual_issue_sched dual_issue_sched_chk i_chk (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_ready(q_ready), .q_unit(q_unit),
    .q_pop(q_pop), .s0_vld(s0_vld), .s0_thr(s0_thr), .s1_vld(s1_vld), .s1_thr(s1_thr),
    .wb_vld(wb_vld), .add_done(add_done), .mul_done(mul_done),
    .add_res(add_res), .mul_res(mul_res), .hold_vld(hold_vld)
);

// File: tb/test_dual_issue_sched.sv
module test_dual_issue_sched;
    import dis_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NTHR-1:0]    q_valid = '0, q_ready = '0, q_unit = 4'b1010;
    logic [NTHR*RW-1:0] q_dst;
    logic [NTHR*DW-1:0] q_opa, q_opb;
    logic [NTHR-1:0]    q_pop;
    logic               s0_vld, s1_vld, wb_vld;
    logic [TW-1:0]      s0_thr, s1_thr, wb_thr;
    logic [RW-1:0]      wb_dst;
    logic [DW-1:0]      wb_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_issue_sched i_dual_issue_sched (.*);

    // Row: valid, ready, s0v, s0t, s1v, s1t, wbv, wbt, wbdata
    localparam int ROWS = 14;
    localparam logic [32:0] TBL [ROWS] = '{
        {4'b1111, 4'b1111, 1'b1, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0, 16'd0},
        {4'b1111, 4'b1111, 1'b1, 2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 16'd0},
        {4'b1111, 4'b1111, 1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 2'd0, 16'd8},
        {4'b1111, 4'b1111, 1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 2'd2, 16'd14},
        {4'b1111, 4'b1111, 1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 2'd1, 16'd28},
        {4'b0000, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 16'd28},
        {4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 16'd66},
        {4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 16'd28},
        {4'b0010, 4'b0010, 1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 2'd3, 16'd66},
        {4'b1111, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0},
        {4'b0001, 4'b0001, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0},
        {4'b0000, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0},
        {4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 16'd28},
        {4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 16'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; q_valid = '1; q_ready = '1;
        repeat (3) @(negedge clk);
        #1;
        check("R10 no pop in reset", 32'(q_pop), 0);
        check("R10 wb idle in reset", 32'(wb_vld), 0);
        q_valid = '0; q_ready = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic walk(input string pass);
        for (int r = 0; r < ROWS; r++) begin
            logic [32:0] v;
            logic [3:0]  pexp;
            v = TBL[r];
            if (r > 0) @(negedge clk);
            q_valid = v[32:29];
            q_ready = v[28:25];
            #1;
            pexp = (v[24] ? 4'(1 << v[23:22]) : 4'd0) | (v[21] ? 4'(1 << v[20:19]) : 4'd0);
            check({pass, " R5/R7 slot0 valid"}, 32'(s0_vld), 32'(v[24]));
            if (v[24]) check({pass, " R5/R7 slot0 thread"}, 32'(s0_thr), 32'(v[23:22]));
            check({pass, " R6 slot1 valid"}, 32'(s1_vld), 32'(v[21]));
            if (v[21]) check({pass, " R6 slot1 thread"}, 32'(s1_thr), 32'(v[20:19]));
            if (s0_vld && s1_vld) check({pass, " R2 distinct"}, 32'(s0_thr != s1_thr), 1);
            check({pass, " R4 pop"}, 32'(q_pop), 32'(pexp));
            check({pass, " R1 count"}, 32'($countones(q_pop) <= 2), 1);
            check({pass, " R8/R9 wb valid"}, 32'(wb_vld), 32'(v[18]));
            if (v[18]) begin
                check({pass, " R8/R9 wb thread"}, 32'(wb_thr), 32'(v[17:16]));
                check({pass, " R9 wb dst"}, 32'(wb_dst), 32'(v[17:16]) + 4);
                check({pass, " R9 wb data"}, 32'(wb_data), 32'(v[15:0]));
            end
        end
    endtask

    initial begin
        for (int t = 0; t < NTHR; t++) begin
            q_dst[t*RW +: RW] = RW'(t + 4);
            q_opa[t*DW +: DW] = DW'(t + 3);
            q_opb[t*DW +: DW] = DW'(2 * t + 5);
        end
        do_reset();
        walk("first");
        do_reset();
        walk("R11 replay");

        // R3: two adder threads never pair; rotation wraps (R5).
        do_reset();
        q_valid = 4'b0101; q_ready = 4'b1111;
        #1;
        check("R3 same unit slot0", 32'(s0_thr), 0);
        check("R3 same unit no slot1", 32'(s1_vld), 0);
        @(negedge clk); #1;
        check("R5 rotate to t2", 32'(s0_thr), 2);
        check("R3 still single", 32'(s1_vld), 0);
        @(negedge clk); #1;
        check("R5 wrap to t0", 32'(s0_thr), 0);
        check("R9 add wb t0", 32'(wb_data), 8);
        q_valid = '0;
        @(negedge clk); #1;
        check("R9 add wb t2", 32'(wb_data), 14);
        check("R9 add wb t2 thread", 32'(wb_thr), 2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule